// File: doc/BRIEF.md
# Chunk-Localizing Parity Codec

This block protects a memory word with a small number of check bits. It cannot correct an error. It detects any single flipped bit and reports which chunk of the stored codeword holds it. Each bit of the codeword belongs to one chunk. Every bit in a chunk shares the same nonzero parity-check column, so `CHK_W` check bits give 2^CHK_W − 1 distinct locations. The write side computes the check bits combinationally from the data. The read side recomputes the syndrome. A registered output stage then returns the received data, an error flag and a chunk index one cycle later.

When a read carries an error, the error flag acts as a precise exception request for that read. In the same cycle, an error-information register captures the chunk index and the raw received codeword, provided it is empty. It holds them until software clears it. Any further error that arrives while the register is occupied sets a sticky overflow bit and leaves the stored contents unchanged.

The chunk layout is a parameter: one column value per data bit. A second parameter maps each nonzero syndrome to a chunk index. A chunk that is given a single data bit locates that bit exactly, so that bit can be corrected by software. In the default layout, 32 data bits and 3 check bits form seven 5-bit chunks.

Top module: `clp_codec`

## Requirements
- R1: `wr_chk_o[j]` is the XOR of every data bit whose column has bit j set. In the default layout, data bits 31..27 use column 7, bits 26..22 use column 6, bits 21..17 use column 5, bits 16..13 use column 4, bits 12..8 use column 3, bits 7..4 use column 2 and bits 3..0 use column 1. Check bit j uses column 2^j. The codeword is {check bits, data}, with check bit 0 at codeword bit 32.
- R2: A read whose received codeword has a zero syndrome produces `rd_err_o`=0 and `rd_chunk_o`=0, and the read is not captured.
- R3: A read with exactly one flipped codeword bit produces `rd_err_o`=1 and a nonzero `rd_chunk_o`. With the default identity map, the chunk index equals the column of the flipped bit.
- R4: The read path has one cycle of latency. `rd_valid_o`, `rd_data_o` (the received data bits, uncorrected), `rd_err_o` and `rd_chunk_o` appear on the clock edge after the read is presented. Back-to-back reads are returned on consecutive cycles.
- R5: `rd_err_o` is the exception request. It is high for exactly the cycle that carries the erroneous read result and is low otherwise.
- R6: On an error while `einfo_valid_o`=0, the register loads the chunk index and the raw 35-bit received codeword and sets `einfo_valid_o`=1, visible in the same cycle as `rd_err_o`. It holds these values until cleared.
- R7: An error while `einfo_valid_o`=1 and no clear is pending sets `einfo_ovf_o`=1 and leaves the stored chunk and codeword unchanged. Overflow never stands without valid.
- R8: `einfo_clr_i` empties the register and clears overflow. If a clear and an error fall in the same cycle, the new error is captured and overflow reads 0.
- R9: Synchronous active-low reset clears every output register and the error-information register.
- R10: A cycle with `rd_valid_i`=0 raises nothing and captures nothing, whatever is on the read bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_data_i | input | DATA_W | Data to encode |
| wr_chk_o | output | CHK_W | Check bits for `wr_data_i` (combinational) |
| rd_valid_i | input | 1 | A stored word is presented for checking |
| rd_data_i | input | DATA_W | Received data bits |
| rd_chk_i | input | CHK_W | Received check bits |
| rd_valid_o | output | 1 | Registered read result valid |
| rd_data_o | output | DATA_W | Received data, one cycle later |
| rd_err_o | output | 1 | Error detected; precise exception request |
| rd_chunk_o | output | CHK_W | Chunk index of the error, 0 when clean |
| einfo_valid_o | output | 1 | Error-information register occupied |
| einfo_chunk_o | output | CHK_W | Captured chunk index |
| einfo_word_o | output | DATA_W+CHK_W | Captured raw codeword |
| einfo_ovf_o | output | 1 | Sticky: another error arrived while occupied |
| einfo_clr_i | input | 1 | Empty the error-information register |

## Verification
Capture of a new error and the software clear can land on the same clock edge. The expected result is that the clear empties the old contents and the new error loads in their place. The bench provokes this by driving `einfo_clr_i` in the same cycle as an erroneous read, while the register already holds an error with overflow set. It then requires the new chunk and codeword, valid high and overflow low. The bench also checks the other collision, a new error against an occupied register with no clear: the stored contents must not move, and overflow must rise.

// File: rtl/clp_pkg.sv
// Package: shared constants and layout helpers for the chunk-localizing codec.
// Assumes at most MAX_DW data bits and at most FW check bits.
package clp_pkg;

    localparam int MAX_DW      = 64;
    localparam int FW          = 4;
    localparam int MAP_ENTRIES = 1 << FW;

    // One FW-bit column value per data bit.
    typedef logic [MAX_DW*FW-1:0]      col_tbl_t;
    // One FW-bit chunk index per syndrome value.
    typedef logic [MAP_ENTRIES*FW-1:0] chunk_map_t;

    // Fill chunks from the top data bit down, highest column first.
    // Each chunk gets an equal share; a chunk whose column has weight 1
    // gives one slot to its check bit.
    function automatic col_tbl_t default_cols(int dw, int r);
        col_tbl_t res;
        int nch;
        int target;
        int b;
        int fill;
        res    = '0;
        nch    = (1 << r) - 1;
        target = (dw + r + nch - 1) / nch;
        b      = dw - 1;
        for (int c = nch; c >= 1; c--) begin
            fill = target - ((((c & (c - 1)) == 0)) ? 1 : 0);
            for (int k = 0; k < fill; k++) begin
                if (b >= 0) begin
                    res[b*FW +: FW] = FW'(c);
                    b--;
                end
            end
        end
        return res;
    endfunction

    // Chunk index equals syndrome value.
    function automatic chunk_map_t identity_map();
        chunk_map_t m;
        for (int s = 0; s < MAP_ENTRIES; s++) begin
            m[s*FW +: FW] = FW'(s);
        end
        return m;
    endfunction

endpackage

// File: rtl/clp_encoder.sv
// Module: computes CHK_W check bits from DATA_W data bits.
// Check bit j is the XOR of the data bits whose column has bit j set.
// Assumes COLS holds one FW-bit column per data bit, with no zero column.
module clp_encoder #(
    parameter int               DATA_W = 32,
    parameter int               CHK_W  = 3,
    parameter clp_pkg::col_tbl_t COLS  = clp_pkg::default_cols(32, 3)
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);

    logic [CHK_W-1:0][DATA_W-1:0] sel;

    // Gather the data bits that feed each check equation, then fold them.
    for (genvar j = 0; j < CHK_W; j++) begin : g_eq
        for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign sel[j][i] = data_i[i] & COLS[i*clp_pkg::FW + j];
        end
        assign chk_o[j] = ^sel[j];
    end

endmodule

// File: rtl/clp_chunk_lookup.sv
// Module: maps a syndrome to a chunk index through the CHUNK_MAP table.
// A zero syndrome gives index 0, meaning no error.
// Assumes every nonzero syndrome maps to a nonzero index.
module clp_chunk_lookup #(
    parameter int                  CHK_W     = 3,
    parameter clp_pkg::chunk_map_t CHUNK_MAP = clp_pkg::identity_map()
) (
    input  logic [CHK_W-1:0] syn_i,
    output logic [CHK_W-1:0] chunk_o
);

    // Table lookup; a clean word is forced to index 0.
    always_comb begin
        if (syn_i == '0) begin
            chunk_o = '0;
        end else begin
            chunk_o = CHUNK_MAP[int'(syn_i)*clp_pkg::FW +: CHK_W];
        end
        // R3: a detected error must name a real chunk.
        if (syn_i != '0) begin
            p_map_nonzero_r3: assert (chunk_o != '0)
                else $error("nonzero syndrome mapped to chunk 0");
        end
    end

endmodule

// File: rtl/clp_check.sv
// Module: read-side checker.
// Re-encodes the received data, XORs the result with the received check
// bits to form the syndrome, and looks up the chunk index.
// Combinational; the caller registers the results.
module clp_check #(
    parameter int                  DATA_W    = 32,
    parameter int                  CHK_W     = 3,
    parameter clp_pkg::col_tbl_t   COLS      = clp_pkg::default_cols(32, 3),
    parameter clp_pkg::chunk_map_t CHUNK_MAP = clp_pkg::identity_map()
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  chk_i,
    output logic [CHK_W-1:0]  syn_o,
    output logic [CHK_W-1:0]  chunk_o
);

    logic [CHK_W-1:0] recomputed;

    clp_encoder #(
        .DATA_W (DATA_W),
        .CHK_W  (CHK_W),
        .COLS   (COLS)
    ) i_reenc (
        .data_i (data_i),
        .chk_o  (recomputed)
    );

    // Syndrome: the column of a single flipped bit.
    assign syn_o = recomputed ^ chk_i;

    clp_chunk_lookup #(
        .CHK_W     (CHK_W),
        .CHUNK_MAP (CHUNK_MAP)
    ) i_lookup (
        .syn_i   (syn_o),
        .chunk_o (chunk_o)
    );

endmodule

// File: rtl/clp_err_info.sv
// Module: error-information register with sticky overflow.
// Loads the chunk and raw codeword on the first error and holds them until
// cleared. A clear that coincides with an error captures the new error.
// Assumes cap_i is already qualified by a valid read.
module clp_err_info #(
    parameter int CHK_W = 3,
    parameter int CW_W  = 35
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_i,
    input  logic [CHK_W-1:0] cap_chunk_i,
    input  logic [CW_W-1:0]  cap_word_i,
    input  logic             clr_i,
    output logic             valid_o,
    output logic [CHK_W-1:0] chunk_o,
    output logic [CW_W-1:0]  word_o,
    output logic             ovf_o
);

    // Capture, hold, overflow and clear; the clear empties the register first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            chunk_o <= '0;
            word_o  <= '0;
            ovf_o   <= 1'b0;
        end else if (clr_i) begin
            ovf_o   <= 1'b0;
            valid_o <= cap_i;
            chunk_o <= cap_i ? cap_chunk_i : '0;
            word_o  <= cap_i ? cap_word_i : '0;
        end else if (cap_i) begin
            if (!valid_o) begin
                valid_o <= 1'b1;
                chunk_o <= cap_chunk_i;
                word_o  <= cap_word_i;
            end else begin
                ovf_o <= 1'b1;
            end
        end
    end

    // R6: contents hold while nothing touches them.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !clr_i && !cap_i |=> valid_o && $stable(chunk_o) && $stable(word_o));

    // R7: an error against an occupied register sets overflow and keeps contents.
    p_ovf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && cap_i && !clr_i |=> ovf_o && $stable(chunk_o) && $stable(word_o));

    // R7: overflow never stands without valid contents.
    p_ovf_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> valid_o);

    // R8: clear and capture together leave the new error and no overflow.
    p_clr_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && cap_i |=> valid_o && !ovf_o && chunk_o == $past(cap_chunk_i));

endmodule

// File: rtl/clp_codec.sv
// Module: top of the chunk-localizing parity codec.
// The write side encodes combinationally. The read side checks the word
// and returns the received data, an error flag and a chunk index after one
// register stage, and feeds the error-information register.
// Assumes 1 <= CHK_W <= 4 and DATA_W <= 64.
module clp_codec #(
    parameter int                  DATA_W    = 32,
    parameter int                  CHK_W     = 3,
    parameter clp_pkg::col_tbl_t   COLS      = clp_pkg::default_cols(DATA_W, CHK_W),
    parameter clp_pkg::chunk_map_t CHUNK_MAP = clp_pkg::identity_map()
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [DATA_W-1:0]         wr_data_i,
    output logic [CHK_W-1:0]          wr_chk_o,
    input  logic                      rd_valid_i,
    input  logic [DATA_W-1:0]         rd_data_i,
    input  logic [CHK_W-1:0]          rd_chk_i,
    output logic                      rd_valid_o,
    output logic [DATA_W-1:0]         rd_data_o,
    output logic                      rd_err_o,
    output logic [CHK_W-1:0]          rd_chunk_o,
    output logic                      einfo_valid_o,
    output logic [CHK_W-1:0]          einfo_chunk_o,
    output logic [DATA_W+CHK_W-1:0]   einfo_word_o,
    output logic                      einfo_ovf_o,
    input  logic                      einfo_clr_i
);

    localparam int CW_W = DATA_W + CHK_W;

    logic [CHK_W-1:0] syn;
    logic [CHK_W-1:0] chunk;
    logic             detect;

    clp_encoder #(
        .DATA_W (DATA_W),
        .CHK_W  (CHK_W),
        .COLS   (COLS)
    ) i_wr_enc (
        .data_i (wr_data_i),
        .chk_o  (wr_chk_o)
    );

    clp_check #(
        .DATA_W    (DATA_W),
        .CHK_W     (CHK_W),
        .COLS      (COLS),
        .CHUNK_MAP (CHUNK_MAP)
    ) i_check (
        .data_i  (rd_data_i),
        .chk_i   (rd_chk_i),
        .syn_o   (syn),
        .chunk_o (chunk)
    );

    // An error is only meaningful on a presented read.
    assign detect = rd_valid_i && (syn != '0);

    // Output register stage: one cycle of read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
            rd_err_o   <= 1'b0;
            rd_chunk_o <= '0;
        end else begin
            rd_valid_o <= rd_valid_i;
            rd_err_o   <= detect;
            rd_chunk_o <= detect ? chunk : '0;
            if (rd_valid_i) begin
                rd_data_o <= rd_data_i;
            end
        end
    end

    clp_err_info #(
        .CHK_W (CHK_W),
        .CW_W  (CW_W)
    ) i_einfo (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_i       (detect),
        .cap_chunk_i (chunk),
        .cap_word_i  ({rd_chk_i, rd_data_i}),
        .clr_i       (einfo_clr_i),
        .valid_o     (einfo_valid_o),
        .chunk_o     (einfo_chunk_o),
        .word_o      (einfo_word_o),
        .ovf_o       (einfo_ovf_o)
    );

    // R2: a clean read reports no error.
    p_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_i && syn == '0 |=> !rd_err_o && rd_chunk_o == '0);

    // R3 / R5: a nonzero syndrome raises the request with a real chunk next cycle.
    p_err_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_i && syn != '0 |=> rd_err_o && rd_chunk_o != '0);

    // R4: the received data appears one cycle later, with valid.
    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_i |=> rd_valid_o && rd_data_o == $past(rd_data_i));

    // R10: an idle cycle raises nothing.
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid_i |=> !rd_valid_o && !rd_err_o);

endmodule

// File: tb/test_clp_codec.sv
// Bench for clp_codec: a vector table walked by one loop, then directed
// tests for the read pipeline, the capture register, collisions and reset.
module test_clp_codec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic [2:0]  wr_chk_o;
    logic        rd_valid_i = 1'b0;
    logic [31:0] rd_data_i = '0;
    logic [2:0]  rd_chk_i = '0;
    logic        rd_valid_o;
    logic [31:0] rd_data_o;
    logic        rd_err_o;
    logic [2:0]  rd_chunk_o;
    logic        einfo_valid_o;
    logic [2:0]  einfo_chunk_o;
    logic [34:0] einfo_word_o;
    logic        einfo_ovf_o;
    logic        einfo_clr_i = 1'b0;

    int errors = 0;
    int total  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    clp_codec i_clp_codec (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_data_i     (wr_data_i),
        .wr_chk_o      (wr_chk_o),
        .rd_valid_i    (rd_valid_i),
        .rd_data_i     (rd_data_i),
        .rd_chk_i      (rd_chk_i),
        .rd_valid_o    (rd_valid_o),
        .rd_data_o     (rd_data_o),
        .rd_err_o      (rd_err_o),
        .rd_chunk_o    (rd_chunk_o),
        .einfo_valid_o (einfo_valid_o),
        .einfo_chunk_o (einfo_chunk_o),
        .einfo_word_o  (einfo_word_o),
        .einfo_ovf_o   (einfo_ovf_o),
        .einfo_clr_i   (einfo_clr_i)
    );

    typedef struct packed {
        logic [31:0] data;
        logic        flip;
        logic [5:0]  idx;
        logic        exp_err;
        logic [2:0]  exp_chunk;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 1'b0, 6'd0,  1'b0, 3'd0},
        '{32'hFFFF_FFFF, 1'b0, 6'd0,  1'b0, 3'd0},
        '{32'hA5A5_3C3C, 1'b1, 6'd0,  1'b1, 3'd1},
        '{32'h1234_5678, 1'b1, 6'd31, 1'b1, 3'd7},
        '{32'hDEAD_BEEF, 1'b1, 6'd32, 1'b1, 3'd1},
        '{32'h0F0F_F0F0, 1'b1, 6'd33, 1'b1, 3'd2},
        '{32'h8000_0001, 1'b1, 6'd34, 1'b1, 3'd4},
        '{32'h7FFF_FFFE, 1'b1, 6'd13, 1'b1, 3'd4},
        '{32'h0000_FFFF, 1'b1, 6'd12, 1'b1, 3'd3},
        '{32'hCAFE_F00D, 1'b1, 6'd17, 1'b1, 3'd5},
        '{32'h1357_9BDF, 1'b1, 6'd22, 1'b1, 3'd6},
        '{32'h2468_ACE0, 1'b1, 6'd7,  1'b1, 3'd2},
        '{32'h5555_AAAA, 1'b1, 6'd26, 1'b1, 3'd6},
        '{32'h0BAD_CAFE, 1'b1, 6'd8,  1'b1, 3'd3}
    };

    // Column of a data bit, per the default layout in R1.
    function automatic logic [2:0] bench_col(int i);
        if (i >= 27)      return 3'd7;
        else if (i >= 22) return 3'd6;
        else if (i >= 17) return 3'd5;
        else if (i >= 13) return 3'd4;
        else if (i >= 8)  return 3'd3;
        else if (i >= 4)  return 3'd2;
        else              return 3'd1;
    endfunction

    function automatic logic [2:0] bench_chk(logic [31:0] d);
        logic [2:0] c = '0;
        for (int i = 0; i < 32; i++) begin
            for (int j = 0; j < 3; j++) begin
                if (bench_col(i)[j]) c[j] = c[j] ^ d[i];
            end
        end
        return c;
    endfunction

    function automatic logic [34:0] mkword(logic [31:0] d, logic flip, int idx);
        logic [34:0] w = {bench_chk(d), d};
        if (flip) w = w ^ (35'd1 << idx);
        return w;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one cycle of inputs at a falling edge; outputs are then
    // sampled at the next falling edge, after the capturing rising edge.
    task automatic step(logic v, logic [34:0] w, logic clr);
        @(negedge clk);
        rd_valid_i  = v;
        rd_data_i   = w[31:0];
        rd_chk_i    = w[34:32];
        einfo_clr_i = clr;
        @(negedge clk);
        rd_valid_i  = 1'b0;
        einfo_clr_i = 1'b0;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            total++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, total);
            $finish;
        end
    end

    initial begin
        logic [34:0] w;
        logic [34:0] wq;
        logic [34:0] wkeep;

        // R9: reset state.
        repeat (3) @(negedge clk);
        check("R9 rd_valid_o reset", rd_valid_o, 0);
        check("R9 rd_err_o reset", rd_err_o, 0);
        check("R9 einfo_valid_o reset", einfo_valid_o, 0);
        check("R9 einfo_ovf_o reset", einfo_ovf_o, 0);
        rst_n = 1'b1;

        // Vector table: encoding, detection, chunk index, capture.
        for (int v = 0; v < NV; v++) begin
            wr_data_i = VECS[v].data;
            #1;
            check("R1 wr_chk_o", wr_chk_o, bench_chk(VECS[v].data));
            w = mkword(VECS[v].data, VECS[v].flip, int'(VECS[v].idx));
            step(1'b1, w, 1'b0);
            check("R4 rd_valid_o", rd_valid_o, 1);
            check("R4 rd_data_o", rd_data_o, w[31:0]);
            check(VECS[v].exp_err ? "R3 rd_err_o" : "R2 rd_err_o", rd_err_o, VECS[v].exp_err);
            check(VECS[v].exp_err ? "R3 rd_chunk_o" : "R2 rd_chunk_o", rd_chunk_o, VECS[v].exp_chunk);
            check(VECS[v].exp_err ? "R6 einfo_valid_o" : "R2 einfo_valid_o", einfo_valid_o, VECS[v].exp_err);
            if (VECS[v].exp_err) begin
                check("R6 einfo_chunk_o", einfo_chunk_o, VECS[v].exp_chunk);
                check("R6 einfo_word_o", einfo_word_o, w);
            end
            step(1'b0, '0, 1'b1);
            check("R8 einfo_valid_o cleared", einfo_valid_o, 0);
        end

        // R4 / R5: back-to-back reads, clean then erroneous.
        w  = mkword(32'h0BEE_F00D, 1'b0, 0);
        wq = mkword(32'h600D_CAFE, 1'b1, 10);
        @(negedge clk);
        rd_valid_i = 1'b1; rd_data_i = w[31:0]; rd_chk_i = w[34:32];
        @(negedge clk);
        check("R4 first of pair data", rd_data_o, w[31:0]);
        check("R5 first of pair no request", rd_err_o, 0);
        rd_data_i = wq[31:0]; rd_chk_i = wq[34:32];
        @(negedge clk);
        rd_valid_i = 1'b0;
        check("R4 second of pair data", rd_data_o, wq[31:0]);
        check("R5 second of pair request", rd_err_o, 1);
        check("R3 second of pair chunk", rd_chunk_o, 3);
        @(negedge clk);
        check("R5 request lasts one cycle", rd_err_o, 0);

        // R6: holds across idle cycles.
        repeat (3) @(negedge clk);
        check("R6 hold valid", einfo_valid_o, 1);
        check("R6 hold chunk", einfo_chunk_o, 3);
        check("R6 hold word", einfo_word_o, wq);
        check("R7 no overflow yet", einfo_ovf_o, 0);
        wkeep = wq;

        // R7: second error while occupied.
        w = mkword(32'h3141_5926, 1'b1, 30);
        step(1'b1, w, 1'b0);
        check("R7 rd_chunk_o of second error", rd_chunk_o, 7);
        check("R7 overflow set", einfo_ovf_o, 1);
        check("R7 chunk unchanged", einfo_chunk_o, 3);
        check("R7 word unchanged", einfo_word_o, wkeep);

        // R10: corrupt bus with no valid read.
        w = mkword(32'hFACE_B00C, 1'b1, 0);
        step(1'b0, w, 1'b0);
        check("R10 rd_valid_o idle", rd_valid_o, 0);
        check("R10 rd_err_o idle", rd_err_o, 0);
        check("R10 einfo_chunk_o untouched", einfo_chunk_o, 3);
        check("R10 einfo_word_o untouched", einfo_word_o, wkeep);
        check("R10 overflow untouched", einfo_ovf_o, 1);

        // R8: clear and new error in the same cycle.
        w = mkword(32'h2718_2818, 1'b1, 33);
        step(1'b1, w, 1'b1);
        check("R8 collision valid", einfo_valid_o, 1);
        check("R8 collision chunk", einfo_chunk_o, 2);
        check("R8 collision word", einfo_word_o, w);
        check("R8 collision overflow", einfo_ovf_o, 0);

        // R8: clear alone.
        step(1'b0, '0, 1'b1);
        check("R8 clear valid", einfo_valid_o, 0);
        check("R8 clear overflow", einfo_ovf_o, 0);

        // R9: reset mid-run with a captured error.
        w = mkword(32'h0000_0001, 1'b1, 20);
        step(1'b1, w, 1'b0);
        check("R9 pre-reset captured", einfo_valid_o, 1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset valid", einfo_valid_o, 0);
        check("R9 reset chunk", einfo_chunk_o, 0);
        check("R9 reset rd_err_o", rd_err_o, 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end

endmodule